// File: doc/BRIEF.md
# Power Event Interrupt Router

This block gathers power-management event pulses and general-purpose input events, latches each one in its own status bit, and steers the enabled ones to one of two signalling paths. One path is a firmware-level management interrupt: an active-low output, `smi_n`. Once it asserts, it holds until software writes the end-of-interrupt bit. It is then kept high for a guaranteed gap before it can assert again. The other path is an operating-system-level control interrupt. It is a level signal that stays active while any enabled source still has status pending. It is driven onto one selectable interrupt request line with a selectable polarity.

Software reaches the block through a small word-wide register port with four registers: status, enable, control and routing. Status bits are write-one-to-clear. A single mode bit in control chooses which path the enabled events use. Only the lowest sixteen general-purpose inputs can ever become event sources.

Top module: `pm_event_router`

## Requirements
- R1: A pulse on `fix_evt[i]` sets status bit i on the next clock edge. The bit stays set until status is written with 1 in that bit position. An event in the same cycle as a clear of its bit leaves the bit set. Writing 0 has no effect.
- R2: `gpi_evt[k]` for k in 0..15 sets status bit 8+k. Inputs 16 and above never change any status bit.
- R3: The enable register (address 1, bits 23:0) reads back what was written. Enables do not gate the setting of status bits.
- R4: With control bit 0 (mode) at 0, control bit 1 (global enable) at 1 and the end-of-interrupt bit armed, an enabled status bit causes `smi_n` to go low one clock after the status bit becomes visible. With global enable at 0, or mode at 1, `smi_n` stays high.
- R5: Once low, `smi_n` stays low until control is written with bit 2 = 1. Control bit 2 reads 1 after reset and after that write. It reads 0 from the edge on which `smi_n` asserts, and a new assertion needs it to be 1.
- R6: After the end-of-interrupt write, `smi_n` is high for at least GAP_CLKS+1 clock cycles (5 with defaults). If an enabled event is still pending after that, it goes low again.
- R7: With mode at 1, the control interrupt is active while any bit of status AND enable is 1. It goes inactive only when all such bits are cleared.
- R8: The routing register (address 3) holds select in bits 2:0, advanced-mode in bit 3 and unshared in bit 4. Select 0..2 picks line 9..11 (pins 0..2). With advanced-mode 1, select 4..7 picks line 20..23 (pins 3..6). A write of any other combination is ignored and the previous routing is kept.
- R9: Pins not selected are held at 1. The selected pin is active-low (idle 1) when unshared is 0. It is active-high (idle 0) when unshared is 1.
- R10: After reset, status, enable and routing read 0, control reads 0x4, `smi_n` is 1 and every `sci_pin` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_evt | input | NUM_FIX | Fixed power-management event pulses |
| gpi_evt | input | GPI_W | General-purpose input event pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 enable, 2 control, 3 routing |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Register read data for `addr` (combinational) |
| smi_n | output | 1 | Active-low management interrupt |
| sci_pin | output | NUM_LEGACY+NUM_EXT | Interrupt request lines: 9, 10, 11, 20, 21, 22, 23 |

## Verification
A wrong status or enable bit shows on `rd_data` the cycle after the event or write. It also shows on the interrupt outputs one cycle later for `smi_n`, or in that same cycle for the control pins. A stuck or mis-counted handshake state shows as `smi_n` releasing without a write, or re-asserting inside the gap. The reference model catches both on the first wrong clock, not at the end of a sequence. Routing faults appear at once as a wrong pin, or a wrong idle level on an otherwise quiet line.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_STS   = 2'd0;
   localparam logic [ADDR_W-1:0] A_EN    = 2'd1;
   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
   localparam logic [ADDR_W-1:0] A_ROUTE = 2'd3;

   localparam int CTRL_MODE = 0;
   localparam int CTRL_GLB  = 1;
   localparam int CTRL_EOS  = 2;

   localparam int SEL_W    = 3;
   localparam int EXT_BASE = 4;

   typedef struct packed {
      logic             unshared;
      logic             adv;
      logic [SEL_W-1:0] sel;
   } route_t;

   localparam int ROUTE_W = $bits(route_t);
endpackage

// File: rtl/pmr_status_bank.sv
module pmr_status_bank #(
   parameter int NUM_FIX   = 8,
   parameter int GPI_W     = 32,
   parameter int ROUTE_GPI = 16,
   localparam int NSRC     = NUM_FIX + ROUTE_GPI
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_FIX-1:0] fix_evt,
   input  logic [GPI_W-1:0] gpi_evt,
   input  logic             sts_wr,
   input  logic             en_wr,
   input  logic [NSRC-1:0]  wdata,
   output logic [NSRC-1:0]  sts,
   output logic [NSRC-1:0]  en
);
   logic [NSRC-1:0] evt_vec;
   logic            unused_hi_gpi;

   assign evt_vec       = {gpi_evt[ROUTE_GPI-1:0], fix_evt};
   assign unused_hi_gpi = ^(gpi_evt >> ROUTE_GPI);

   for (genvar b = 0; b < NSRC; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sts[b] <= 1'b0;
         end else if (evt_vec[b]) begin
            sts[b] <= 1'b1;
         end else if (sts_wr && wdata[b]) begin
            sts[b] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (en_wr) en <= wdata;
   end
endmodule

// File: rtl/pmr_smi_seq.sv
module pmr_smi_seq #(
   parameter int GAP_CLKS = 4,
   localparam int CW      = $clog2(GAP_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic eos_set,
   output logic smi_n,
   output logic eos
);
   logic          act_q;
   logic [CW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         gap_q <= '0;
         eos   <= 1'b1;
      end else if (act_q) begin
         if (eos_set) begin
            act_q <= 1'b0;
            eos   <= 1'b1;
            gap_q <= CW'(GAP_CLKS);
         end
      end else begin
         if (gap_q != '0) gap_q <= gap_q - 1'b1;
         if (eos_set) eos <= 1'b1;
         if (pending && eos && gap_q == '0) begin
            act_q <= 1'b1;
            eos   <= 1'b0;
         end
      end
   end

   assign smi_n = ~act_q;
endmodule

// File: rtl/pmr_sci_route.sv
module pmr_sci_route
   import pmr_pkg::*;
#(
   parameter int NUM_LEGACY = 3,
   parameter int NUM_EXT    = 4,
   localparam int NUM_PINS  = NUM_LEGACY + NUM_EXT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                route_wr,
   input  route_t              route_in,
   input  logic                sci_req,
   output route_t              route,
   output logic [NUM_PINS-1:0] sci_pin
);
   logic legal;

   always_comb begin
      legal = 1'b0;
      if (int'(route_in.sel) < NUM_LEGACY) legal = 1'b1;
      if (route_in.adv && int'(route_in.sel) >= EXT_BASE &&
          int'(route_in.sel) < EXT_BASE + NUM_EXT) legal = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 route <= '0;
      else if (route_wr && legal) route <= route_in;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int CODE = (p < NUM_LEGACY) ? p : EXT_BASE + p - NUM_LEGACY;
      logic hit;
      if (p < NUM_LEGACY) begin : g_leg
         assign hit = (route.sel == SEL_W'(CODE));
      end else begin : g_ext
         assign hit = (route.sel == SEL_W'(CODE)) && route.adv;
      end
      assign sci_pin[p] = hit ? (route.unshared ? sci_req : ~sci_req) : 1'b1;
   end
endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
   import pmr_pkg::*;
#(
   parameter int NUM_FIX    = 8,
   parameter int GPI_W      = 32,
   parameter int ROUTE_GPI  = 16,
   parameter int GAP_CLKS   = 4,
   parameter int NUM_LEGACY = 3,
   parameter int NUM_EXT    = 4,
   parameter int DATA_W     = 32,
   localparam int NSRC      = NUM_FIX + ROUTE_GPI,
   localparam int NUM_PINS  = NUM_LEGACY + NUM_EXT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FIX-1:0]  fix_evt,
   input  logic [GPI_W-1:0]    gpi_evt,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   output logic                smi_n,
   output logic [NUM_PINS-1:0] sci_pin
);
   if (NSRC > DATA_W) begin : g_chk_width
      $error("pm_event_router: sources exceed data width");
   end
   if (ROUTE_GPI > GPI_W || ROUTE_GPI < 1) begin : g_chk_gpi
      $error("pm_event_router: ROUTE_GPI out of range");
   end
   if (GAP_CLKS < 4) begin : g_chk_gap
      $error("pm_event_router: GAP_CLKS below minimum of 4");
   end
   if (NUM_LEGACY < 1 || NUM_LEGACY > EXT_BASE || NUM_EXT > (1 << SEL_W) - EXT_BASE) begin : g_chk_lines
      $error("pm_event_router: line counts do not fit select encoding");
   end
   if (DATA_W < ROUTE_W) begin : g_chk_dw
      $error("pm_event_router: data width too small");
   end

   logic [NSRC-1:0] sts_q, en_q;
   logic            sci_mode_q, smi_glb_q, eos_q;
   logic            any_pend, smi_pend, sci_req, eos_set;
   route_t          route_q;
   logic            unused_wd;

   assign unused_wd = ^(wr_data >> NSRC);

   pmr_status_bank #(.NUM_FIX(NUM_FIX), .GPI_W(GPI_W), .ROUTE_GPI(ROUTE_GPI)) u_bank (
      .clk(clk), .rst_n(rst_n), .fix_evt(fix_evt), .gpi_evt(gpi_evt),
      .sts_wr(wr_en && addr == A_STS), .en_wr(wr_en && addr == A_EN),
      .wdata(wr_data[NSRC-1:0]), .sts(sts_q), .en(en_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sci_mode_q <= 1'b0;
         smi_glb_q  <= 1'b0;
      end else if (wr_en && addr == A_CTRL) begin
         sci_mode_q <= wr_data[CTRL_MODE];
         smi_glb_q  <= wr_data[CTRL_GLB];
      end
   end

   assign any_pend = |(sts_q & en_q);
   assign smi_pend = any_pend && smi_glb_q && !sci_mode_q;
   assign sci_req  = any_pend && sci_mode_q;
   assign eos_set  = wr_en && addr == A_CTRL && wr_data[CTRL_EOS];

   pmr_smi_seq #(.GAP_CLKS(GAP_CLKS)) u_smi (
      .clk(clk), .rst_n(rst_n), .pending(smi_pend), .eos_set(eos_set),
      .smi_n(smi_n), .eos(eos_q)
   );

   pmr_sci_route #(.NUM_LEGACY(NUM_LEGACY), .NUM_EXT(NUM_EXT)) u_route (
      .clk(clk), .rst_n(rst_n), .route_wr(wr_en && addr == A_ROUTE),
      .route_in(route_t'(wr_data[ROUTE_W-1:0])), .sci_req(sci_req),
      .route(route_q), .sci_pin(sci_pin)
   );

   always_comb begin
      rd_data = '0;
      case (addr)
         A_STS:   rd_data[NSRC-1:0] = sts_q;
         A_EN:    rd_data[NSRC-1:0] = en_q;
         A_CTRL: begin
            rd_data[CTRL_MODE] = sci_mode_q;
            rd_data[CTRL_GLB]  = smi_glb_q;
            rd_data[CTRL_EOS]  = eos_q;
         end
         default: rd_data[ROUTE_W-1:0] = route_q;
      endcase
   end
endmodule

// File: rtl/pm_event_router_chk.sv
module pm_event_router_chk
   import pmr_pkg::*;
#(
   parameter int NUM_FIX    = 8,
   parameter int NSRC       = 24,
   parameter int NUM_PINS   = 7,
   parameter int NUM_LEGACY = 3,
   parameter int GAP_CLKS   = 4,
   parameter int DATA_W     = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic [NUM_FIX-1:0]  fix_evt,
   input logic                smi_n,
   input logic [NUM_PINS-1:0] sci_pin,
   input logic [NSRC-1:0]     sts,
   input logic [NSRC-1:0]     en,
   input logic                sci_mode,
   input logic                smi_glb,
   input route_t              route
);
   localparam int HW = $clog2(GAP_CLKS + 3);
   logic [HW-1:0] hi_cnt;
   logic          eos_wr;

   assign eos_wr = wr_en && addr == A_CTRL && wr_data[CTRL_EOS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             hi_cnt <= HW'(GAP_CLKS + 1);
      else if (!smi_n)                        hi_cnt <= '0;
      else if (hi_cnt < HW'(GAP_CLKS + 1))    hi_cnt <= hi_cnt + 1'b1;
   end

   assert_evt_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|fix_evt) |=> ((sts[NUM_FIX-1:0] & $past(fix_evt)) == $past(fix_evt)));

   assert_smi_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smi_n) |-> ($past(smi_glb) && !$past(sci_mode)));

   assert_smi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!smi_n && !eos_wr) |=> !smi_n);

   assert_smi_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smi_n) |-> (hi_cnt >= HW'(GAP_CLKS + 1)));

   assert_sci_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_mode && |(sts & en)) |-> (route.unshared ? (|sci_pin) : !(&sci_pin)));

   assert_sci_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(sci_mode && |(sts & en)) |-> (route.unshared ? !(&sci_pin) : (&sci_pin)));

   assert_route_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(route.sel) < NUM_LEGACY) || (route.adv && int'(route.sel) >= EXT_BASE));

   assert_one_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sci_pin) >= NUM_PINS - 1);
endmodule

bind pm_event_router pm_event_router_chk #(
   .NUM_FIX(NUM_FIX), .NSRC(NSRC), .NUM_PINS(NUM_PINS),
   .NUM_LEGACY(NUM_LEGACY), .GAP_CLKS(GAP_CLKS), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .fix_evt(fix_evt), .smi_n(smi_n), .sci_pin(sci_pin), .sts(sts_q), .en(en_q),
   .sci_mode(sci_mode_q), .smi_glb(smi_glb_q), .route(route_q)
);

// File: tb/test_pm_event_router.sv
module test_pm_event_router;
   localparam int GAP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  fix_evt = '0;
   logic [31:0] gpi_evt = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        smi_n;
   logic [6:0]  sci_pin;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   pm_event_router i_pm_event_router (
      .clk(clk), .rst_n(rst_n), .fix_evt(fix_evt), .gpi_evt(gpi_evt),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .smi_n(smi_n), .sci_pin(sci_pin)
   );

   // behavioural reference
   bit [23:0] m_sts, m_en;
   bit        m_mode, m_glb, m_eos, m_act, m_adv, m_unsh;
   bit [2:0]  m_sel;
   int        m_gap;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   function automatic bit [31:0] m_read(input logic [1:0] a);
      case (a)
         2'd0: return {8'h0, m_sts};
         2'd1: return {8'h0, m_en};
         2'd2: return {29'h0, m_eos, m_glb, m_mode};
         default: return {27'h0, m_unsh, m_adv, m_sel};
      endcase
   endfunction

   function automatic bit [6:0] m_pins();
      bit [6:0] p = 7'h7f;
      bit sci = m_mode && ((m_sts & m_en) != 0);
      int idx = (m_sel < 3) ? int'(m_sel) : 3 + int'(m_sel) - 4;
      p[idx] = m_unsh ? sci : !sci;
      return p;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_sts = '0; m_en = '0; m_mode = 0; m_glb = 0; m_eos = 1; m_act = 0;
         m_gap = 0; m_sel = 0; m_adv = 0; m_unsh = 0;
      end else begin
         bit pend, eos_w, old_eos;
         int old_gap;
         bit [23:0] nsts;
         pend  = !m_mode && m_glb && ((m_sts & m_en) != 0);
         eos_w = wr_en && addr == 2'd2 && wr_data[2];
         if (m_act) begin
            if (eos_w) begin m_act = 0; m_eos = 1; m_gap = GAP; end
         end else begin
            old_eos = m_eos; old_gap = m_gap;
            if (m_gap > 0) m_gap--;
            if (eos_w) m_eos = 1;
            if (pend && old_eos && old_gap == 0) begin m_act = 1; m_eos = 0; end
         end
         nsts = m_sts;
         if (wr_en && addr == 2'd0) nsts &= ~wr_data[23:0];
         nsts |= {gpi_evt[15:0], fix_evt};
         m_sts = nsts;
         if (wr_en && addr == 2'd1) m_en = wr_data[23:0];
         if (wr_en && addr == 2'd2) begin m_mode = wr_data[0]; m_glb = wr_data[1]; end
         if (wr_en && addr == 2'd3) begin
            if (wr_data[2:0] < 3 || (wr_data[3] && wr_data[2:0] >= 4)) begin
               m_sel = wr_data[2:0]; m_adv = wr_data[3]; m_unsh = wr_data[4];
            end
         end
      end
   end

   // per-cycle comparison, away from the edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         check(smi_n === !m_act, "R4 R5 R6 smi_n", {31'h0, smi_n}, {31'h0, !m_act});
         check(sci_pin === m_pins(), "R7 R9 sci_pin", {25'h0, sci_pin}, {25'h0, m_pins()});
         check(rd_data === m_read(addr), "R3 rd_data", rd_data, m_read(addr));
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1; addr = a; wr_data = d;
      @(negedge clk); wr_en = 0; wr_data = '0;
   endtask

   task automatic pulse(input logic [7:0] f, input logic [31:0] g);
      @(negedge clk); fix_evt = f; gpi_evt = g;
      @(negedge clk); fix_evt = '0; gpi_evt = '0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); addr = a;
      @(posedge clk); #2;
      check(rd_data === exp, tag, rd_data, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      check(smi_n === 1'b1, "R10 smi_n", {31'h0, smi_n}, 32'h1);
      check(sci_pin === 7'h7f, "R10 sci_pin", {25'h0, sci_pin}, 32'h7f);
      rd_chk(2'd0, 32'h0, "R10 status");
      rd_chk(2'd1, 32'h0, "R10 enable");
      rd_chk(2'd2, 32'h4, "R10 control");
      rd_chk(2'd3, 32'h0, "R10 routing");

      // R1 latch, hold, clear, event wins over clear
      pulse(8'h01, 0);
      idle(3);
      rd_chk(2'd0, 32'h1, "R1 latched");
      wr(2'd0, 32'h0);
      rd_chk(2'd0, 32'h1, "R1 write 0 no effect");
      @(negedge clk); wr_en = 1; addr = 2'd0; wr_data = 32'h1; fix_evt = 8'h01;
      @(negedge clk); wr_en = 0; wr_data = 0; fix_evt = 0;
      rd_chk(2'd0, 32'h1, "R1 event beats clear");
      wr(2'd0, 32'h1);
      rd_chk(2'd0, 32'h0, "R1 cleared");

      // R2 general-purpose input range
      pulse(0, 32'hFFFF_0000);
      rd_chk(2'd0, 32'h0, "R2 upper inputs ignored");
      pulse(0, 32'h0000_8002);
      rd_chk(2'd0, 32'h0080_0200, "R2 inputs 1 and 15");
      wr(2'd0, 32'hFF_FFFF);

      // R3 enable readback, no gating of status
      wr(2'd1, 32'hA5_5A3C);
      rd_chk(2'd1, 32'hA5_5A3C, "R3 enable readback");
      wr(2'd1, 32'h0);
      pulse(8'h80, 0);
      rd_chk(2'd0, 32'h80, "R3 status set while disabled");
      wr(2'd0, 32'h80);

      // R4 global enable gating
      wr(2'd1, 32'h1);
      wr(2'd2, 32'h0);
      pulse(8'h01, 0);
      idle(4);
      check(smi_n === 1'b1, "R4 global enable off", {31'h0, smi_n}, 32'h1);
      wr(2'd0, 32'h1);
      // mode selects SCI: no SMI
      wr(2'd2, 32'h3);
      pulse(8'h01, 0);
      idle(4);
      check(smi_n === 1'b1, "R4 mode 1 blocks SMI", {31'h0, smi_n}, 32'h1);
      wr(2'd0, 32'h1);

      // R4/R5 assertion and hold
      wr(2'd2, 32'h2);
      pulse(8'h01, 0);
      idle(1);
      check(smi_n === 1'b0, "R4 smi asserted", {31'h0, smi_n}, 32'h0);
      rd_chk(2'd2, 32'h2, "R5 end bit self-cleared");
      idle(10);
      check(smi_n === 1'b0, "R5 held low", {31'h0, smi_n}, 32'h0);

      // R6 gap then re-assert while still pending
      wr(2'd2, 32'h6);
      hi = 0;
      if (smi_n) hi = 1;
      for (int k = 0; k < 20 && smi_n; k++) begin
         @(posedge clk); #2;
         if (smi_n) hi++;
      end
      check(hi == GAP + 1, "R6 gap length", hi, GAP + 1);
      check(smi_n === 1'b0, "R6 re-asserted", {31'h0, smi_n}, 32'h0);
      wr(2'd0, 32'h1);
      wr(2'd2, 32'h6);
      idle(10);
      check(smi_n === 1'b1, "R5 released when cleared", {31'h0, smi_n}, 32'h1);
      // pending but not rearmed: end bit set by write already, so fire again
      pulse(8'h01, 0);
      idle(2);
      check(smi_n === 1'b0, "R5 armed fires", {31'h0, smi_n}, 32'h0);
      wr(2'd0, 32'h1);
      wr(2'd2, 32'h4);

      // R7 level SCI
      wr(2'd1, 32'h201);
      wr(2'd2, 32'h1);
      pulse(8'h01, 32'h2);
      check(sci_pin === 7'h7e, "R7 active low on line 9", {25'h0, sci_pin}, 32'h7e);
      wr(2'd0, 32'h1);
      check(sci_pin === 7'h7e, "R7 still one source", {25'h0, sci_pin}, 32'h7e);
      wr(2'd0, 32'h200);
      check(sci_pin === 7'h7f, "R7 all cleared", {25'h0, sci_pin}, 32'h7f);

      // R8 routing legality
      wr(2'd3, 32'h3);
      rd_chk(2'd3, 32'h0, "R8 select 3 ignored");
      wr(2'd3, 32'h5);
      rd_chk(2'd3, 32'h0, "R8 ext line needs advanced mode");
      wr(2'd3, 32'h0D);
      rd_chk(2'd3, 32'h0D, "R8 line 21 accepted");
      wr(2'd3, 32'h1D);
      check(sci_pin === 7'h6f, "R9 unshared idle low", {25'h0, sci_pin}, 32'h6f);
      pulse(8'h01, 0);
      check(sci_pin === 7'h7f, "R9 unshared active high", {25'h0, sci_pin}, 32'h7f);
      wr(2'd3, 32'h02);
      check(sci_pin === 7'h7b, "R9 line 11 active low", {25'h0, sci_pin}, 32'h7b);
      wr(2'd0, 32'h1);
      idle(2);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #400000;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule